// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block keeps a short, time-ordered list of hardware prefetch requests waiting to be sent out by a cache. A demand-miss port tells it when the cache has missed. The miss cancels any queued prefetch to the same block. When serial-squash is enabled, the miss also discards the newest entries whose ready time is not earlier than the miss time. The latched miss time then becomes the base time for the candidates that an external address calculator streams in next.

Each candidate is filtered before it is appended:
- it is dropped if it is already outstanding in the miss-status queue;
- it is dropped if it is already queued;
- when push-time checking is selected, it is dropped if it is already cached.

A full queue gives up its oldest entry to make room. An issue handshake pops the head entry. When push-time checking is off, the cache check runs at issue time instead, and heads found in the cache are skipped one per cycle. A bus-request output stays high, carrying the ready time of the newest insertion, for as long as the queue holds anything. Six event counters record what happened to the candidates.

A single state machine orders the work. The states are:
- `ST_IDLE`: accepts a miss, an issue request or one candidate.
- `ST_PURGE`: removes the entry that matches the miss block.
- `ST_SQUASH`: removes one tail entry per cycle.
- `ST_ISSUE`: pops head entries until one can be issued or the queue is empty.

The transitions are:
- IDLE→PURGE on an accepted miss.
- IDLE→ISSUE on an issue request when no miss is present.
- PURGE→SQUASH when serial-squash is on.
- PURGE→IDLE when serial-squash is off.
- SQUASH→SQUASH while the tail qualifies for removal.
- SQUASH→IDLE when the tail no longer qualifies.
- ISSUE→ISSUE while heads that are already cached are skipped.
- ISSUE→IDLE when the issue completes.

Top module: `pf_queue_mgr`

## Requirements
- R1: The block address is the input address ANDed with the complement of (BLK_BYTES-1): 64-byte blocks by default, so the low 6 bits are cleared. All queue matching compares block addresses, and `iss_addr` is always a block address.
- R2: A miss with `miss_uncache`=1 has no effect. A miss with `miss_ifetch`=1 has no effect while `cfg_data_only`=1. An ignored miss does not update the base time for candidates.
- R3: An accepted miss removes the queued entry whose block equals the miss block, if there is one, and increments `cnt_miss_removed`.
- R4: With `cfg_serial_squash`=1, after the purge the tail entry is removed, one per cycle, while its ready time is greater than or equal to the miss time (unsigned compare). Removal stops at the first earlier entry or when the queue is empty. Each removal increments `cnt_squashed`.
- R5: A candidate's ready time is the latest accepted miss time plus `cand_delay`, truncated to TIME_W bits. Candidates are appended at the tail in arrival order, so issue order is arrival order.
- R6: A candidate is discarded in either of two cases: `mshr_hit` is set, or its block is already queued, in which case `cnt_dup` is incremented. With `cfg_push_check`=1, a candidate is also discarded when `cache_hit` is set for it.
- R7: When a surviving candidate meets a full queue (DEPTH entries), the head entry is dropped first, `cnt_evicted` is incremented, and the new entry is appended.
- R8: Every insertion sets `bus_req`=1 with `bus_time` equal to that entry's ready time. `bus_req` returns to 0 when the queue becomes empty, whether through issue, miss removal or squash.
- R9: An issue request yields one `iss_done` pulse. The pulse carries `iss_valid`=1 and the head block in `iss_addr` and increments `cnt_issued`, unless the queue is empty, in which case `iss_valid`=0.
- R10: With `cfg_push_check`=0, a popped head for which `cache_hit` is set is dropped, and the next head is tried in the following cycle. If every remaining entry was cached, `iss_done` comes with `iss_valid`=0.
- R11: When a miss and an issue request arrive in the same cycle, the miss purge and squash are completed first, and the issue is served from the updated queue.
- R12: `cnt_identified` counts every candidate accepted on the candidate stream, whatever its fate.
- R13: After reset the queue is empty, `bus_req`=0, all counters are 0 and `miss_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data_only | input | 1 | Ignore misses that are instruction fetches |
| cfg_serial_squash | input | 1 | Enable tail squash on a miss |
| cfg_push_check | input | 1 | 1: cache check at push; 0: cache check at issue |
| miss_valid | input | 1 | Demand miss present |
| miss_ready | output | 1 | Miss accepted this cycle (machine idle) |
| miss_addr | input | ADDR_W | Miss address |
| miss_time | input | TIME_W | Miss timestamp |
| miss_uncache | input | 1 | Miss is uncacheable |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate present |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | ADDR_W | Candidate address |
| cand_delay | input | DELAY_W | Candidate delay after the miss time |
| cache_lkup_addr | output | ADDR_W | Block looked up in the cache |
| cache_hit | input | 1 | Looked-up block is cached (same cycle) |
| mshr_lkup_addr | output | ADDR_W | Block looked up in the miss-status queue |
| mshr_hit | input | 1 | Looked-up block is outstanding (same cycle) |
| iss_req | input | 1 | Issue request, held until `iss_done` |
| iss_done | output | 1 | Issue response strobe |
| iss_valid | output | 1 | Response carries a prefetch |
| iss_addr | output | ADDR_W | Issued block address |
| bus_req | output | 1 | Bus request for prefetch traffic |
| bus_time | output | TIME_W | Ready time of newest insertion |
| cnt_identified | output | CNT_W | Candidates accepted |
| cnt_dup | output | CNT_W | Candidates already queued |
| cnt_evicted | output | CNT_W | Heads dropped for space |
| cnt_miss_removed | output | CNT_W | Entries removed by matching miss |
| cnt_squashed | output | CNT_W | Entries removed by squash |
| cnt_issued | output | CNT_W | Prefetches issued |

## Verification
The assertions check four properties on every cycle:
- the occupancy never exceeds the depth;
- the bus request tracks a non-empty queue exactly;
- a squash step removes exactly one entry while the tail qualifies and returns to idle once it does not;
- a duplicate candidate leaves the occupancy unchanged, an insertion into a full queue keeps it full, and an ignored miss keeps the machine idle.

Only the bench scenarios can show the rest:
- the actual ordering of the queue, including the entry that survives an eviction, a purge or a squash that stops at an earlier entry;
- the skipping of cached heads at issue time;
- the miss-before-issue ordering when both arrive together;
- the block-address masking and the ready-time arithmetic.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PURGE  = 2'd1,
        ST_SQUASH = 2'd2,
        ST_ISSUE  = 2'd3
    } pfq_state_e;

    localparam int EV_IDENT  = 0;
    localparam int EV_DUP    = 1;
    localparam int EV_EVICT  = 2;
    localparam int EV_MISSRM = 3;
    localparam int EV_SQUASH = 4;
    localparam int EV_ISSUED = 5;
    localparam int NUM_EV    = 6;

endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int TIME_W = 16,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rm_en,
    input  logic [OCC_W-1:0]  rm_idx,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TIME_W-1:0] push_time,
    output logic [ADDR_W-1:0] slot_addr [DEPTH],
    output logic [TIME_W-1:0] slot_time [DEPTH],
    output logic [OCC_W-1:0]  occ
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [TIME_W-1:0] time_q [DEPTH];
    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [TIME_W-1:0] time_d [DEPTH];
    logic [OCC_W-1:0]  occ_q, occ_mid, occ_d;

    // Removal compacts toward slot 0, then a push lands at the new tail.
    always_comb begin
        addr_d  = addr_q;
        time_d  = time_q;
        occ_mid = occ_q;
        if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (OCC_W'(i) >= rm_idx) begin
                    addr_d[i] = addr_q[i+1];
                    time_d[i] = time_q[i+1];
                end
            end
            occ_mid = occ_q - 1'b1;
        end
        occ_d = occ_mid;
        if (push_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (OCC_W'(i) == occ_mid) begin
                    addr_d[i] = push_addr;
                    time_d[i] = push_time;
                end
            end
            occ_d = occ_mid + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                time_q[i] <= '0;
            end
        end else begin
            occ_q  <= occ_d;
            addr_q <= addr_d;
            time_q <= time_d;
        end
    end

    assign slot_addr = addr_q;
    assign slot_time = time_q;
    assign occ       = occ_q;

endmodule

// File: rtl/pfq_match.sv
module pfq_match #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [OCC_W-1:0]  occ,
    input  logic [ADDR_W-1:0] key,
    output logic              hit,
    output logic [OCC_W-1:0]  hit_idx
);

    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = (OCC_W'(g) < occ) && (slot_addr[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = OCC_W'(i);
        end
    end

    assign hit = |eq;

endmodule

// File: rtl/pfq_evcount.sv
module pfq_evcount #(
    parameter int NUM   = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   inc,
    output logic [CNT_W-1:0] cnt [NUM]
);

    for (genvar g = 0; g < NUM; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt[g] <= '0;
            else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/pf_queue_mgr.sv
module pf_queue_mgr
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 32,
    parameter int TIME_W    = 16,
    parameter int DELAY_W   = 8,
    parameter int BLK_BYTES = 64,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_data_only,
    input  logic               cfg_serial_squash,
    input  logic               cfg_push_check,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [ADDR_W-1:0]  miss_addr,
    input  logic [TIME_W-1:0]  miss_time,
    input  logic               miss_uncache,
    input  logic               miss_ifetch,
    input  logic               cand_valid,
    output logic               cand_ready,
    input  logic [ADDR_W-1:0]  cand_addr,
    input  logic [DELAY_W-1:0] cand_delay,
    output logic [ADDR_W-1:0]  cache_lkup_addr,
    input  logic               cache_hit,
    output logic [ADDR_W-1:0]  mshr_lkup_addr,
    input  logic               mshr_hit,
    input  logic               iss_req,
    output logic               iss_done,
    output logic               iss_valid,
    output logic [ADDR_W-1:0]  iss_addr,
    output logic               bus_req,
    output logic [TIME_W-1:0]  bus_time,
    output logic [CNT_W-1:0]   cnt_identified,
    output logic [CNT_W-1:0]   cnt_dup,
    output logic [CNT_W-1:0]   cnt_evicted,
    output logic [CNT_W-1:0]   cnt_miss_removed,
    output logic [CNT_W-1:0]   cnt_squashed,
    output logic [CNT_W-1:0]   cnt_issued
);

    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~(ADDR_W'(BLK_BYTES - 1));

    pfq_state_e state_q, state_d;

    logic [ADDR_W-1:0] miss_blk_q;
    logic [TIME_W-1:0] miss_time_q;
    logic              bus_req_q;
    logic [TIME_W-1:0] bus_time_q;

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [TIME_W-1:0] slot_time [DEPTH];
    logic [OCC_W-1:0]  occ;

    logic              rm_en, push_en, load_miss;
    logic [OCC_W-1:0]  rm_idx;
    logic [TIME_W-1:0] push_time;
    logic [NUM_EV-1:0] ev;

    logic [ADDR_W-1:0] miss_blk, cand_blk, match_key, head_addr;
    logic [TIME_W-1:0] tail_time;
    logic              q_empty, q_full, miss_ok;
    logic              m_hit;
    logic [OCC_W-1:0]  m_idx;
    logic              drop_cache, drop_mshr, cand_dup, cand_ins;
    logic              head_cached;
    logic              squash_step;

    logic [CNT_W-1:0]  ctr [NUM_EV];

    // R1: block addresses clear the offset bits
    assign miss_blk  = miss_addr & BLK_MASK;
    assign cand_blk  = cand_addr & BLK_MASK;
    assign head_addr = slot_addr[0];
    assign q_empty   = (occ == '0);
    assign q_full    = (occ == OCC_W'(DEPTH));

    // R2: uncacheable misses, and ifetch misses in data-only mode, are ignored
    assign miss_ok = !miss_uncache && !(miss_ifetch && cfg_data_only);

    always_comb begin
        tail_time = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (OCC_W'(i) == occ - 1'b1) tail_time = slot_time[i];
        end
    end

    assign match_key = (state_q == ST_PURGE) ? miss_blk_q : cand_blk;

    pfq_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .TIME_W (TIME_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rm_en     (rm_en),
        .rm_idx    (rm_idx),
        .push_en   (push_en),
        .push_addr (cand_blk),
        .push_time (push_time),
        .slot_addr (slot_addr),
        .slot_time (slot_time),
        .occ       (occ)
    );

    pfq_match #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_match (
        .slot_addr (slot_addr),
        .occ       (occ),
        .key       (match_key),
        .hit       (m_hit),
        .hit_idx   (m_idx)
    );

    pfq_evcount #(
        .NUM   (NUM_EV),
        .CNT_W (CNT_W)
    ) u_evcount (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev),
        .cnt   (ctr)
    );

    // Lookups: the cache port follows the head while issuing, else the candidate.
    assign cache_lkup_addr = (state_q == ST_ISSUE) ? head_addr : cand_blk;
    assign mshr_lkup_addr  = cand_blk;

    // R6: filter order is cache (push mode), miss-status queue, own queue
    assign drop_cache = cfg_push_check && cache_hit;
    assign drop_mshr  = !drop_cache && mshr_hit;
    assign cand_dup   = !drop_cache && !drop_mshr && m_hit;
    assign cand_ins   = !drop_cache && !drop_mshr && !m_hit;

    // R5: ready time relative to the latched miss time
    assign push_time = miss_time_q + TIME_W'(cand_delay);

    // R10: issue-time cache check only when push-time checking is off
    assign head_cached = !cfg_push_check && cache_hit;

    // R4: tail qualifies for squash
    assign squash_step = !q_empty && (tail_time >= miss_time_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions and queue operations
    always_comb begin
        state_d   = state_q;
        rm_en     = 1'b0;
        rm_idx    = '0;
        push_en   = 1'b0;
        load_miss = 1'b0;
        ev        = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid) begin
                    // R11: a miss wins over a pending issue request
                    if (miss_ok) begin
                        load_miss = 1'b1;
                        state_d   = ST_PURGE;
                    end
                end else if (iss_req) begin
                    state_d = ST_ISSUE;
                end else if (cand_valid) begin
                    ev[EV_IDENT] = 1'b1;
                    ev[EV_DUP]   = cand_dup;
                    if (cand_ins) begin
                        push_en = 1'b1;
                        if (q_full) begin
                            // R7: make room by dropping the head
                            rm_en        = 1'b1;
                            rm_idx       = '0;
                            ev[EV_EVICT] = 1'b1;
                        end
                    end
                end
            end
            ST_PURGE: begin
                // R3: at most one entry can match the miss block
                if (m_hit) begin
                    rm_en         = 1'b1;
                    rm_idx        = m_idx;
                    ev[EV_MISSRM] = 1'b1;
                end
                state_d = cfg_serial_squash ? ST_SQUASH : ST_IDLE;
            end
            ST_SQUASH: begin
                if (squash_step) begin
                    rm_en         = 1'b1;
                    rm_idx        = occ - 1'b1;
                    ev[EV_SQUASH] = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ISSUE: begin
                if (q_empty) begin
                    state_d = ST_IDLE;
                end else begin
                    rm_en  = 1'b1;
                    rm_idx = '0;
                    if (!head_cached) begin
                        ev[EV_ISSUED] = 1'b1;
                        state_d       = ST_IDLE;
                    end else if (occ == OCC_W'(1)) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Miss latch and bus request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_blk_q  <= '0;
            miss_time_q <= '0;
            bus_req_q   <= 1'b0;
            bus_time_q  <= '0;
        end else begin
            if (load_miss) begin
                miss_blk_q  <= miss_blk;
                miss_time_q <= miss_time;
            end
            // R8: set on insertion, clear when the last entry leaves
            if (push_en) begin
                bus_req_q  <= 1'b1;
                bus_time_q <= push_time;
            end else if (rm_en && occ == OCC_W'(1)) begin
                bus_req_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        miss_ready = (state_q == ST_IDLE);
        cand_ready = (state_q == ST_IDLE) && !miss_valid && !iss_req;
        iss_done   = (state_q == ST_ISSUE) &&
                     (q_empty || !head_cached || occ == OCC_W'(1));
        iss_valid  = (state_q == ST_ISSUE) && !q_empty && !head_cached;
        iss_addr   = head_addr;
    end

    assign bus_req          = bus_req_q;
    assign bus_time         = bus_time_q;
    assign cnt_identified   = ctr[EV_IDENT];
    assign cnt_dup          = ctr[EV_DUP];
    assign cnt_evicted      = ctr[EV_EVICT];
    assign cnt_miss_removed = ctr[EV_MISSRM];
    assign cnt_squashed     = ctr[EV_SQUASH];
    assign cnt_issued       = ctr[EV_ISSUED];

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
    import pfq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 16,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input pfq_state_e        state,
    input logic [OCC_W-1:0]  occ,
    input logic [TIME_W-1:0] tail_time,
    input logic [TIME_W-1:0] miss_time_q,
    input logic              bus_req,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              miss_uncache,
    input logic              cand_valid,
    input logic              cand_ready,
    input logic              cand_dup,
    input logic              push_en,
    input logic              iss_done,
    input logic              iss_valid
);

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    p_bus_tracks_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req == (occ != '0));

    p_squash_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SQUASH && occ != '0 && tail_time >= miss_time_q)
        |=> occ == OCC_W'($past(occ) - 1'b1));

    p_squash_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SQUASH && (occ == '0 || tail_time < miss_time_q))
        |=> (state == ST_IDLE && $stable(occ)));

    p_dup_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready && cand_dup) |=> $stable(occ));

    p_full_stays_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && occ == OCC_W'(DEPTH)) |=> occ == OCC_W'(DEPTH));

    p_ignored_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && miss_uncache) |=> state == ST_IDLE);

    p_valid_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_done);

endmodule

bind pf_queue_mgr pfq_checker #(
    .DEPTH  (DEPTH),
    .TIME_W (TIME_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .occ          (occ),
    .tail_time    (tail_time),
    .miss_time_q  (miss_time_q),
    .bus_req      (bus_req),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .miss_uncache (miss_uncache),
    .cand_valid   (cand_valid),
    .cand_ready   (cand_ready),
    .cand_dup     (cand_dup),
    .push_en      (push_en),
    .iss_done     (iss_done),
    .iss_valid    (iss_valid)
);

// File: tb/pf_queue_mgr_tb.sv
module pf_queue_mgr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_data_only = 1'b0, cfg_serial_squash = 1'b0, cfg_push_check = 1'b0;
    logic        miss_valid = 1'b0, miss_ready;
    logic [31:0] miss_addr = '0;
    logic [15:0] miss_time = '0;
    logic        miss_uncache = 1'b0, miss_ifetch = 1'b0;
    logic        cand_valid = 1'b0, cand_ready;
    logic [31:0] cand_addr = '0;
    logic [7:0]  cand_delay = '0;
    logic [31:0] cache_lkup_addr, mshr_lkup_addr;
    logic        cache_hit, mshr_hit;
    logic        iss_req = 1'b0, iss_done, iss_valid;
    logic [31:0] iss_addr;
    logic        bus_req;
    logic [15:0] bus_time;
    logic [15:0] cnt_identified, cnt_dup, cnt_evicted, cnt_miss_removed, cnt_squashed, cnt_issued;

    logic        tb_cache_en = 1'b0, tb_mshr_en = 1'b0;
    logic [31:0] tb_cache_blk = '0, tb_mshr_blk = '0;

    assign cache_hit = tb_cache_en && (cache_lkup_addr == tb_cache_blk);
    assign mshr_hit  = tb_mshr_en && (mshr_lkup_addr == tb_mshr_blk);

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pf_queue_mgr u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
        .cfg_push_check(cfg_push_check),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .miss_time(miss_time), .miss_uncache(miss_uncache), .miss_ifetch(miss_ifetch),
        .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
        .cand_delay(cand_delay),
        .cache_lkup_addr(cache_lkup_addr), .cache_hit(cache_hit),
        .mshr_lkup_addr(mshr_lkup_addr), .mshr_hit(mshr_hit),
        .iss_req(iss_req), .iss_done(iss_done), .iss_valid(iss_valid), .iss_addr(iss_addr),
        .bus_req(bus_req), .bus_time(bus_time),
        .cnt_identified(cnt_identified), .cnt_dup(cnt_dup), .cnt_evicted(cnt_evicted),
        .cnt_miss_removed(cnt_miss_removed), .cnt_squashed(cnt_squashed),
        .cnt_issued(cnt_issued)
    );

    // {input address, delay, expected block address}
    localparam logic [71:0] VECS [6] = '{
        {32'h0000_1234, 8'd3,   32'h0000_1200},
        {32'h0000_103F, 8'd0,   32'h0000_1000},
        {32'hABCD_EF7F, 8'd7,   32'hABCD_EF40},
        {32'h0000_0040, 8'd1,   32'h0000_0040},
        {32'hFFFF_FFFF, 8'd255, 32'hFFFF_FFC0},
        {32'h1234_5680, 8'd9,   32'h1234_5680}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (!miss_ready) @(negedge clk);
    endtask

    task automatic do_miss(input logic [31:0] a, input logic [15:0] t,
                           input logic unc, input logic ifc);
        @(negedge clk);
        wait_idle();
        miss_valid = 1'b1; miss_addr = a; miss_time = t;
        miss_uncache = unc; miss_ifetch = ifc;
        @(negedge clk);
        miss_valid = 1'b0; miss_uncache = 1'b0; miss_ifetch = 1'b0;
        wait_idle();
    endtask

    task automatic push(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!cand_ready) @(negedge clk);
        cand_valid = 1'b1; cand_addr = a; cand_delay = d;
        @(negedge clk);
        cand_valid = 1'b0;
    endtask

    task automatic issue(output logic v, output logic [31:0] a);
        @(negedge clk);
        wait_idle();
        iss_req = 1'b1;
        @(negedge clk);
        while (!iss_done) @(negedge clk);
        v = iss_valid;
        a = iss_addr;
        iss_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic        v;
        logic [31:0] a;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        check("R13 bus_req", {31'd0, bus_req}, 32'd0);
        check("R13 miss_ready", {31'd0, miss_ready}, 32'd1);
        check("R13 cnt_identified", {16'd0, cnt_identified}, 32'd0);
        check("R13 cnt_issued", {16'd0, cnt_issued}, 32'd0);

        // Vector table: R1 masking, R5 ready time, R8 bus request, R9 issue
        do_miss(32'hF000_0000, 16'd100, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            push(VECS[k][71:40], VECS[k][39:32]);
            check("R8 bus_req after push", {31'd0, bus_req}, 32'd1);
            check("R5 bus_time", {16'd0, bus_time}, 32'd100 + {24'd0, VECS[k][39:32]});
            issue(v, a);
            check("R9 iss_valid", {31'd0, v}, 32'd1);
            check("R1 block address", a, VECS[k][31:0]);
            @(negedge clk);
            check("R8 bus_req after drain", {31'd0, bus_req}, 32'd0);
        end
        issue(v, a);
        check("R9 empty issue", {31'd0, v}, 32'd0);

        // R5: arrival order and latest bus time
        do_miss(32'hF000_0000, 16'd200, 1'b0, 1'b0);
        push(32'h100, 8'd5); push(32'h200, 8'd3); push(32'h300, 8'd9);
        check("R5 bus_time newest", {16'd0, bus_time}, 32'd209);
        issue(v, a); check("R5 order 1", a, 32'h100);
        issue(v, a); check("R5 order 2", a, 32'h200);
        issue(v, a); check("R5 order 3", a, 32'h300);

        // R6: filters
        push(32'h400, 8'd1);
        push(32'h410, 8'd1);
        check("R6 cnt_dup", {16'd0, cnt_dup}, 32'd1);
        tb_mshr_en = 1'b1; tb_mshr_blk = 32'h500;
        push(32'h500, 8'd1);
        tb_mshr_en = 1'b0;
        cfg_push_check = 1'b1; tb_cache_en = 1'b1; tb_cache_blk = 32'h600;
        push(32'h600, 8'd1);
        tb_cache_en = 1'b0;
        issue(v, a); check("R6 survivor", a, 32'h400);
        issue(v, a); check("R6 filtered ones absent", {31'd0, v}, 32'd0);
        cfg_push_check = 1'b0;

        // R7: eviction of the head when full
        for (int k = 1; k <= 9; k++) push(32'(k) << 12, 8'd2);
        check("R7 cnt_evicted", {16'd0, cnt_evicted}, 32'd1);
        for (int k = 2; k <= 9; k++) begin
            issue(v, a);
            check("R7 drain order", a, 32'(k) << 12);
        end

        // R3: matching miss removes entry
        push(32'hA000, 8'd1); push(32'hB000, 8'd1); push(32'hC000, 8'd1);
        do_miss(32'hB010, 16'd300, 1'b0, 1'b0);
        check("R3 cnt_miss_removed", {16'd0, cnt_miss_removed}, 32'd1);
        issue(v, a); check("R3 first", a, 32'hA000);
        issue(v, a); check("R3 second", a, 32'hC000);
        issue(v, a); check("R3 empty", {31'd0, v}, 32'd0);

        // R2: ignored misses
        push(32'hD000, 8'd1);
        do_miss(32'hD000, 16'd999, 1'b1, 1'b0);
        cfg_data_only = 1'b1;
        do_miss(32'hD000, 16'd999, 1'b0, 1'b1);
        check("R2 entry kept", {31'd0, bus_req}, 32'd1);
        check("R2 no removal", {16'd0, cnt_miss_removed}, 32'd1);
        push(32'hE000, 8'd1);
        check("R2 base time unchanged", {16'd0, bus_time}, 32'd301);
        cfg_data_only = 1'b0;
        do_miss(32'hD000, 16'd400, 1'b0, 1'b1);
        check("R2 ifetch accepted", {16'd0, cnt_miss_removed}, 32'd2);
        issue(v, a); check("R2 remaining", a, 32'hE000);

        // R4: serial squash stops at first earlier entry
        cfg_serial_squash = 1'b1;
        do_miss(32'hF000_0000, 16'd10, 1'b0, 1'b0);
        push(32'h100, 8'd10); push(32'h200, 8'd40); push(32'h300, 8'd20); push(32'h400, 8'd50);
        do_miss(32'hF000_0000, 16'd40, 1'b0, 1'b0);
        check("R4 one squashed", {16'd0, cnt_squashed}, 32'd1);
        issue(v, a); check("R4 keep 1", a, 32'h100);
        issue(v, a); check("R4 keep 2", a, 32'h200);
        issue(v, a); check("R4 keep 3", a, 32'h300);
        do_miss(32'hF000_0000, 16'd0, 1'b0, 1'b0);
        push(32'h500, 8'd5); push(32'h600, 8'd7);
        do_miss(32'hF000_0000, 16'd5, 1'b0, 1'b0);
        check("R4 equal time squashed", {16'd0, cnt_squashed}, 32'd3);
        check("R8 empty after squash", {31'd0, bus_req}, 32'd0);
        cfg_serial_squash = 1'b0;

        // R10: issue-time cache check
        tb_cache_en = 1'b1; tb_cache_blk = 32'h700;
        push(32'h700, 8'd1); push(32'h800, 8'd1);
        issue(v, a); check("R10 skip cached", a, 32'h800);
        push(32'h700, 8'd1);
        issue(v, a); check("R10 all cached", {31'd0, v}, 32'd0);
        @(negedge clk);
        check("R10 bus_req cleared", {31'd0, bus_req}, 32'd0);
        tb_cache_en = 1'b0;

        // R11: miss and issue together
        push(32'h900, 8'd1); push(32'hA00, 8'd1);
        @(negedge clk);
        wait_idle();
        miss_valid = 1'b1; miss_addr = 32'h900; miss_time = 16'd500; iss_req = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        while (!iss_done) @(negedge clk);
        check("R11 issue after purge", iss_addr, 32'hA00);
        iss_req = 1'b0;
        @(negedge clk);

        // Final counter totals
        check("R12 cnt_identified", {16'd0, cnt_identified}, 32'd38);
        check("R6 cnt_dup total", {16'd0, cnt_dup}, 32'd1);
        check("R7 cnt_evicted total", {16'd0, cnt_evicted}, 32'd1);
        check("R3 cnt_miss_removed total", {16'd0, cnt_miss_removed}, 32'd3);
        check("R4 cnt_squashed total", {16'd0, cnt_squashed}, 32'd3);
        check("R9 cnt_issued total", {16'd0, cnt_issued}, 32'd26);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule